// File: doc/BRIEF.md
# Word Copy DMA Engine

This block moves a run of 32-bit words from one memory address to another without processor help. Software sets a source and a destination address through a small register bus. It then writes a word count, and that write starts the transfer. The engine alternates single-word reads and writes on a request/grant master port. After each word written it steps both addresses by four bytes, and it stops when the count reaches zero. A configuration byte decides two things: whether each word has its bytes reversed on the way through, and whether the end of a transfer raises an interrupt. The interrupt stays up until software acknowledges it through its own byte register.

A command register gives access to two read-only values. One command places a fixed device identification word in the result register. A different command reads one word from an internal status source, chosen by a six-bit index, into the result register. Software then reads the result back with a word access.

Top module: `wcopy_dma`

## Requirements
- R1: A word write to 0x00 loads the source address and a word write to 0x04 loads the destination address. A word write of a non-zero count N to 0x08 while idle starts a copy of N words. The master port then issues word k as a read at source+4k, followed by a write of that data at destination+4k, for k = 0 to N-1 in order.
- R2: When configuration bit 7 is clear, each word is written as it was read. When that bit is set, each word is written byte-reversed: read bits 31:24 go to bits 7:0, and so on.
- R3: Once the master request is raised, the request, its direction (mWe, 1 = write), its address and its write data stay unchanged until a cycle in which mGnt is high.
- R4: Status bit 7 (busy) reads 1 from the cycle after the starting count write. It reads 0 in the cycle after the grant of the last write.
- R5: At the end of a copy with configuration bit 0 set, status bit 0 and irq go to 1. With configuration bit 0 clear, neither changes.
- R6: A byte write to 0x0D with data bit 0 set clears status bit 0 and irq. The same write with data bit 0 clear has no effect.
- R7: A count write of zero while idle issues no master request. It completes at once, and it raises status bit 0 and irq when configuration bit 0 is set.
- R8: While the engine is busy, word writes to 0x00, 0x04 and 0x08 are ignored. The running copy keeps its count, and a later copy continues from the addresses the engine reached.
- R9: A word write to the command register 0x10 with bit 29 set loads the result register with the device ID constant. This holds whatever the value of bit 31.
- R10: A command write with bit 29 clear and bit 31 set presents bits 5:0 on statSel and loads the result register with statData. A command with neither bit set leaves the result register unchanged.
- R11: A word write to 0x14 loads the result register with all ones. A word read of 0x14 returns the result register.
- R12: A byte write to 0x0E sets the configuration byte. Byte reads of 0x0C and 0x0E return the status byte and the configuration byte in bits 7:0. All other reads return zero.
- R13: After reset the engine is idle with no request, and irq, status, configuration and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regByte | input | 1 | 1 = byte access (data in bits 7:0), 0 = word access |
| regAddr | input | 5 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| mReq | output | 1 | Master request |
| mWe | output | 1 | Master direction, 1 = write |
| mAddr | output | ADDR_W | Master byte address |
| mWrData | output | 32 | Master write data |
| mGnt | input | 1 | Grant; for reads, mRdData is valid in the same cycle |
| mRdData | input | 32 | Master read data |
| irq | output | 1 | Completion interrupt |
| statSel | output | 6 | Status source index (command bits 5:0) |
| statData | input | 32 | Selected status word |

## Verification
Copies are run with distinct word patterns whose four bytes all differ. A plain copy can therefore be told apart from a reversed one, and a shifted or reordered address sequence shows up as a wrong word at the destination. Zero wait states and several wait states are both used: the first checks the fastest read/write alternation, the second checks that the request holds steady while the grant is missing. Count values of one, several and zero separate the normal end of a copy, the exact busy window and the immediate completion. Register writes issued during a copy show whether the running transfer was disturbed and where the next one starts.

// File: rtl/wcopy_pkg.sv
package wcopy_pkg;
  localparam int WORD_W = 32;

  localparam logic [4:0] REG_SRC  = 5'h00;
  localparam logic [4:0] REG_DST  = 5'h04;
  localparam logic [4:0] REG_LEN  = 5'h08;
  localparam logic [4:0] REG_STAT = 5'h0C;
  localparam logic [4:0] REG_ACK  = 5'h0D;
  localparam logic [4:0] REG_CFG  = 5'h0E;
  localparam logic [4:0] REG_CMD  = 5'h10;
  localparam logic [4:0] REG_RES  = 5'h14;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic ldLen;
    logic capture;
    logic swap;
    logic advance;
    logic resId;
    logic resStat;
    logic resOnes;
  } strobe_t;
endpackage

// File: rtl/wcopy_dpath.sv
module wcopy_dpath
  import wcopy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter logic [WORD_W-1:0] DEV_ID = 32'h5A17_C0DE
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              mWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [WORD_W-1:0] mRdData,
  input  logic [WORD_W-1:0] statData,
  output logic [ADDR_W-1:0] mAddr,
  output logic [WORD_W-1:0] mWrData,
  output logic              lenLast,
  output logic              lenInZero,
  output logic [WORD_W-1:0] result
);
  localparam int NBYTES = WORD_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(NBYTES);

  logic [ADDR_W-1:0] srcPtr, dstPtr;
  logic [LEN_W-1:0]  remain;
  logic [WORD_W-1:0] dataReg, revWord;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign revWord[8*b +: 8] = mRdData[8*(NBYTES-1-b) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr  <= '0;
      dstPtr  <= '0;
      remain  <= '0;
      dataReg <= '0;
      result  <= '0;
    end else begin
      if (stb.ldSrc) srcPtr <= addrIn;
      else if (stb.advance) srcPtr <= srcPtr + ADDR_STEP;
      if (stb.ldDst) dstPtr <= addrIn;
      else if (stb.advance) dstPtr <= dstPtr + ADDR_STEP;
      if (stb.ldLen) remain <= lenIn;
      else if (stb.advance) remain <= remain - LEN_W'(1);
      if (stb.capture) dataReg <= stb.swap ? revWord : mRdData;
      if (stb.resOnes) result <= '1;
      else if (stb.resId) result <= DEV_ID;
      else if (stb.resStat) result <= statData;
    end
  end

  assign mAddr     = mWe ? dstPtr : srcPtr;
  assign mWrData   = dataReg;
  assign lenLast   = (remain == LEN_W'(1));
  assign lenInZero = (lenIn == '0);
endmodule

// File: rtl/wcopy_ctrl.sv
module wcopy_ctrl
  import wcopy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regByte,
  input  logic [4:0]        regAddr,
  input  logic [7:0]        wrLow,
  input  logic              cmdId,
  input  logic              cmdRead,
  input  logic              mGnt,
  input  logic              lenLast,
  input  logic              lenInZero,
  input  logic [WORD_W-1:0] result,
  output strobe_t           stb,
  output logic              mReq,
  output logic              mWe,
  output logic              busy,
  output logic              irq,
  output logic [WORD_W-1:0] regRdData
);
  phase_t ph, phNext;
  logic [7:0] cfg;
  logic irqPend;
  logic wordWr, byteWr, idleWr, finish;

  assign wordWr = regWr && !regByte;
  assign byteWr = regWr && regByte;
  assign idleWr = wordWr && (ph == PH_IDLE);

  always_comb begin
    stb         = '0;
    stb.ldSrc   = idleWr && (regAddr == REG_SRC);
    stb.ldDst   = idleWr && (regAddr == REG_DST);
    stb.ldLen   = idleWr && (regAddr == REG_LEN);
    stb.capture = (ph == PH_READ) && mGnt;
    stb.swap    = cfg[7];
    stb.advance = (ph == PH_WRITE) && mGnt;
    stb.resOnes = wordWr && (regAddr == REG_RES);
    stb.resId   = wordWr && (regAddr == REG_CMD) && cmdId;
    stb.resStat = wordWr && (regAddr == REG_CMD) && !cmdId && cmdRead;
  end

  assign finish = (stb.ldLen && lenInZero) || (stb.advance && lenLast);

  always_comb begin
    phNext = ph;
    case (ph)
      PH_IDLE:  if (stb.ldLen && !lenInZero) phNext = PH_READ;
      PH_READ:  if (mGnt) phNext = PH_WRITE;
      PH_WRITE: if (mGnt) phNext = lenLast ? PH_IDLE : PH_READ;
      default:  phNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph      <= PH_IDLE;
      cfg     <= '0;
      irqPend <= 1'b0;
    end else begin
      ph <= phNext;
      if (byteWr && (regAddr == REG_CFG)) cfg <= wrLow;
      if (finish && cfg[0]) irqPend <= 1'b1;
      else if (byteWr && (regAddr == REG_ACK) && wrLow[0]) irqPend <= 1'b0;
    end
  end

  assign busy = (ph != PH_IDLE);
  assign mReq = busy;
  assign mWe  = (ph == PH_WRITE);
  assign irq  = irqPend;

  always_comb begin
    regRdData = '0;
    if (regByte) begin
      if (regAddr == REG_STAT) regRdData[7:0] = {busy, 6'b0, irqPend};
      else if (regAddr == REG_CFG) regRdData[7:0] = cfg;
    end else if (regAddr == REG_RES) begin
      regRdData = result;
    end
  end
endmodule

// File: rtl/wcopy_dma.sv
module wcopy_dma
  import wcopy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter logic [31:0] DEV_ID = 32'h5A17_C0DE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regByte,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mReq,
  output logic              mWe,
  output logic [ADDR_W-1:0] mAddr,
  output logic [31:0]       mWrData,
  input  logic              mGnt,
  input  logic [31:0]       mRdData,
  output logic              irq,
  output logic [5:0]        statSel,
  input  logic [31:0]       statData
);
  strobe_t stb;
  logic lenLast, lenInZero, busy;
  logic [31:0] result;

  assign statSel = regWrData[5:0];

  wcopy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regByte(regByte), .regAddr(regAddr),
    .wrLow(regWrData[7:0]), .cmdId(regWrData[29]), .cmdRead(regWrData[31]),
    .mGnt(mGnt), .lenLast(lenLast), .lenInZero(lenInZero), .result(result),
    .stb(stb), .mReq(mReq), .mWe(mWe), .busy(busy), .irq(irq), .regRdData(regRdData)
  );

  wcopy_dpath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_ID(DEV_ID)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .mWe(mWe),
    .addrIn(regWrData[ADDR_W-1:0]), .lenIn(regWrData[LEN_W-1:0]),
    .mRdData(mRdData), .statData(statData),
    .mAddr(mAddr), .mWrData(mWrData), .lenLast(lenLast), .lenInZero(lenInZero),
    .result(result)
  );
endmodule

// File: rtl/wcopy_checker.sv
module wcopy_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              regByte,
  input logic [4:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic              mReq,
  input logic              mWe,
  input logic [ADDR_W-1:0] mAddr,
  input logic [31:0]       mWrData,
  input logic              mGnt,
  input logic              irq,
  input logic              busy
);
  logic lenWrIdle;
  assign lenWrIdle = regWr && !regByte && (regAddr == 5'h08) && !busy;

  assert_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    lenWrIdle && (regWrData[LEN_W-1:0] != '0) |=> busy && mReq && !mWe);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    mReq && !mGnt |=> mReq && $stable(mWe) && $stable(mAddr) && (!mWe || $stable(mWrData)));

  assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(mReq && mWe && mGnt));

  assert_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regByte && (regAddr == 5'h0D) && regWrData[0] && !busy |=> !irq);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    lenWrIdle && (regWrData[LEN_W-1:0] == '0) |=> !busy && !mReq);

  assert_ignore_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && regWr && !regByte && (regAddr == 5'h08) && !(mWe && mGnt) |=> busy);
endmodule

bind wcopy_dma wcopy_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regByte(regByte), .regAddr(regAddr),
  .regWrData(regWrData), .mReq(mReq), .mWe(mWe), .mAddr(mAddr), .mWrData(mWrData),
  .mGnt(mGnt), .irq(irq), .busy(busy)
);

// File: tb/wcopy_dma_test.sv
`timescale 1ns/1ps
module wcopy_dma_test;
  localparam logic [31:0] DEV_ID = 32'h5A17_C0DE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regByte = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic mReq, mWe, mGnt = 1'b0, irq;
  logic [31:0] mAddr, mWrData, mRdData = '0, statData;
  logic [5:0] statSel;

  int checks = 0, errors = 0;
  int waitStates = 0, waitCnt = 0;
  logic [31:0] mem [64];
  logic [31:0] rdLog [64];
  logic [31:0] wrLog [64];
  int rdCnt = 0, wrCnt = 0;

  always #4 clk = ~clk;
  assign statData = {8'hA5, 18'h0, statSel};

  wcopy_dma #(.DEV_ID(DEV_ID)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regByte(regByte), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mReq(mReq), .mWe(mWe),
    .mAddr(mAddr), .mWrData(mWrData), .mGnt(mGnt), .mRdData(mRdData), .irq(irq),
    .statSel(statSel), .statData(statData)
  );

  function automatic logic [31:0] initWord(int i);
    return {8'hA0 + 8'(i), 8'h51, 8'h30 + 8'(i), 8'h0F};
  endfunction

  function automatic logic [31:0] rev(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // memory responder
  always @(negedge clk) begin
    if (!rstN || !mReq) begin
      mGnt = 1'b0;
      waitCnt = 0;
    end else if (waitCnt >= waitStates) begin
      mGnt = 1'b1;
      waitCnt = 0;
      if (mWe) begin
        mem[mAddr[7:2]] = mWrData;
        wrLog[wrCnt % 64] = mAddr;
        wrCnt++;
      end else begin
        mRdData = mem[mAddr[7:2]];
        rdLog[rdCnt % 64] = mAddr;
        rdCnt++;
      end
    end else begin
      mGnt = 1'b0;
      waitCnt++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic isByte);
    @(negedge clk);
    regWr = 1'b1; regByte = isByte; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, logic isByte, output logic [31:0] d);
    regAddr = a; regByte = isByte;
    #1 d = regRdData;
  endtask

  task automatic rd(logic [4:0] a, logic isByte, output logic [31:0] d);
    @(negedge clk);
    peek(a, isByte, d);
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(5'h0C, 1'b1, s);
      if (!s[7]) break;
    end
  endtask

  task automatic runCopy(string req, logic [31:0] src, logic [31:0] dst, int n, logic doSwap);
    int r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    wr(5'h00, src, 1'b0);
    wr(5'h04, dst, 1'b0);
    wr(5'h08, 32'(n), 1'b0);
    waitIdle();
    chk({req, " read count"}, 32'(rdCnt - r0), 32'(n));
    chk({req, " write count"}, 32'(wrCnt - w0), 32'(n));
    for (int k = 0; k < n; k++) begin
      chk({req, " read addr"}, rdLog[(r0 + k) % 64], src + 32'(4 * k));
      chk({req, " write addr"}, wrLog[(w0 + k) % 64], dst + 32'(4 * k));
      chk({req, " data"}, mem[(dst >> 2) + 32'(k)],
          doSwap ? rev(initWord(int'(src >> 2) + k)) : initWord(int'(src >> 2) + k));
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R13 mReq", {31'b0, mReq}, 32'd0);
    chk("R13 irq", {31'b0, irq}, 32'd0);
    rd(5'h0C, 1'b1, d); chk("R13 status", d, 32'd0);
    rd(5'h0E, 1'b1, d); chk("R13 config", d, 32'd0);
    rd(5'h14, 1'b0, d); chk("R13 result", d, 32'd0);
  endtask

  task automatic testPlain();
    waitStates = 0;
    runCopy("R1 plain", 32'h00, 32'h80, 3, 1'b0);
    chk("R5 no irq when disabled", {31'b0, irq}, 32'd0);
  endtask

  task automatic testSwap();
    logic [31:0] d;
    wr(5'h0E, 32'h80, 1'b1);
    waitStates = 2;
    runCopy("R2 swap R3 waits", 32'h10, 32'hA0, 3, 1'b1);
    rd(5'h0C, 1'b1, d); chk("R5 no status bit when disabled", d, 32'd0);
    waitStates = 0;
  endtask

  task automatic testBusyIrq();
    logic [31:0] d;
    wr(5'h0E, 32'h01, 1'b1);
    wr(5'h00, 32'h20, 1'b0);
    wr(5'h04, 32'hE0, 1'b0);
    wr(5'h08, 32'd1, 1'b0);
    peek(5'h0C, 1'b1, d); chk("R4 busy first cycle", d, 32'h80);
    @(negedge clk); peek(5'h0C, 1'b1, d); chk("R4 busy second cycle", d, 32'h80);
    chk("R5 irq not yet", {31'b0, irq}, 32'd0);
    @(negedge clk); peek(5'h0C, 1'b1, d); chk("R4 R5 done status", d, 32'h01);
    chk("R5 irq raised", {31'b0, irq}, 32'd1);
    chk("R1 single word", mem[32'hE0 >> 2], initWord(32'h20 >> 2));
    wr(5'h0D, 32'h00, 1'b1);
    peek(5'h0C, 1'b1, d); chk("R6 ack bit0 clear ignored", d, 32'h01);
    wr(5'h0D, 32'h01, 1'b1);
    peek(5'h0C, 1'b1, d); chk("R6 ack clears status", d, 32'h00);
    chk("R6 ack clears irq", {31'b0, irq}, 32'd0);
  endtask

  task automatic testZeroLen();
    logic [31:0] d;
    int r0;
    r0 = rdCnt;
    wr(5'h08, 32'd0, 1'b0);
    peek(5'h0C, 1'b1, d); chk("R7 zero count done at once", d, 32'h01);
    chk("R7 irq", {31'b0, irq}, 32'd1);
    @(negedge clk);
    chk("R7 no request", {31'b0, mReq}, 32'd0);
    chk("R7 no reads", 32'(rdCnt - r0), 32'd0);
    wr(5'h0D, 32'h01, 1'b1);
  endtask

  task automatic testIgnore();
    int r0, w0;
    waitStates = 3;
    r0 = rdCnt; w0 = wrCnt;
    wr(5'h00, 32'h40, 1'b0);
    wr(5'h04, 32'hC0, 1'b0);
    wr(5'h08, 32'd2, 1'b0);
    wr(5'h00, 32'h04, 1'b0);
    wr(5'h04, 32'h08, 1'b0);
    wr(5'h08, 32'd5, 1'b0);
    waitIdle();
    chk("R8 count kept", 32'(wrCnt - w0), 32'd2);
    chk("R8 reads kept", 32'(rdCnt - r0), 32'd2);
    waitStates = 0;
    wr(5'h08, 32'd1, 1'b0);
    waitIdle();
    chk("R8 source continues", rdLog[(rdCnt - 1) % 64], 32'h48);
    chk("R8 destination continues", wrLog[(wrCnt - 1) % 64], 32'hC8);
    chk("R8 data", mem[32'hC8 >> 2], initWord(32'h48 >> 2));
    wr(5'h0D, 32'h01, 1'b1);
  endtask

  task automatic testCommand();
    logic [31:0] d;
    wr(5'h10, 32'h8000_0013, 1'b0);
    rd(5'h14, 1'b0, d); chk("R10 status readback", d, 32'hA500_0013);
    wr(5'h10, 32'hA000_0005, 1'b0);
    rd(5'h14, 1'b0, d); chk("R9 id wins over readback", d, DEV_ID);
    wr(5'h10, 32'h0000_0007, 1'b0);
    rd(5'h14, 1'b0, d); chk("R10 no-op command", d, DEV_ID);
    wr(5'h14, 32'h0000_1234, 1'b0);
    rd(5'h14, 1'b0, d); chk("R11 result ones", d, 32'hFFFF_FFFF);
    wr(5'h10, 32'h2000_0000, 1'b0);
    rd(5'h14, 1'b0, d); chk("R9 id", d, DEV_ID);
  endtask

  task automatic testMap();
    logic [31:0] d;
    wr(5'h0E, 32'h81, 1'b1);
    rd(5'h0E, 1'b1, d); chk("R12 config readback", d, 32'h81);
    rd(5'h00, 1'b0, d); chk("R12 source not readable", d, 32'd0);
    rd(5'h0D, 1'b1, d); chk("R12 unmapped byte", d, 32'd0);
    rd(5'h0C, 1'b0, d); chk("R12 status word read", d, 32'd0);
    rd(5'h14, 1'b1, d); chk("R12 result byte read", d, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = initWord(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPlain();
    testSwap();
    testBusyIrq();
    testZeroLen();
    testIgnore();
    testCommand();
    testMap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule